// File: doc/BRIEF.md
# Audio PWM Speaker Output Stage

This block converts 16-bit signed audio samples into a pair of complementary speaker drive signals, one for the high-side (PMOS) transistor and one for the low-side (NMOS) transistor. At a programmable sample rate it asks an upstream FIFO for a sample. It takes the sample if one is offered and otherwise keeps the previous one, so the output follows a zero-order hold. The held sample is scaled by a fractional gain. A small random dither can be added, and the result is saturated to the signed 16-bit range.

The processed sample is turned into offset binary. Its top bits set the duty of a free-running PWM carrier, and the duty is updated only at the carrier wrap. Complementary drive is formed from the PWM level. An optional dead-time mode leaves both transistors off for one clock at every switching edge. While the block is disabled, both output enables are low, both drives are low, and all hold, dither and carrier state returns to its initial value.

Top module: `spk_pwm_out`

## Requirements
- R1: While `enable` is low, `smp_req` is low. From the first clock edge after `enable` goes low, `hs_oe`, `ls_oe`, `hs_drv` and `ls_drv` are all low. From the first edge after `enable` goes high, both output enables are high.
- R2: While enabled, `smp_req` pulses once every `div_val` clocks. A `div_val` of 0 acts as 1, which makes `smp_req` high on every cycle.
- R3: A sample is loaded into the hold register only in a cycle where `smp_req` and `smp_valid` are both high. If `smp_valid` is low at a request, the previous sample is kept and `smp_data` is ignored.
- R4: The held sample s is scaled as floor(s*(gain_val+1)/256), rounding toward minus infinity. A `gain_val` of 255 is unity gain.
- R5: The sum of the scaled sample and the dither saturates to [-32768, 32767] and never wraps.
- R6: `dither_sel` encodings: 0 adds no dither, 1 adds +1 or -1, 3 adds +2 or -2, and 2 adds no dither. The sign comes from a 16-bit maximal-length LFSR that advances once per sample period.
- R7: With v the saturated value, duty = floor((v+32768)/1024), in the range 0 to 63. The carrier is 64 clocks long. With dead time off, `hs_drv` is high for duty clocks in each carrier period, and a new duty takes effect only at a carrier wrap.
- R8: `hs_drv` and `ls_drv` are never high together. With dead time off and the block enabled, exactly one of them is high.
- R9: With `dead_en` high, each high-side or low-side on-phase loses its first clock. Both drives are low for exactly one clock at each switching edge, so a duty d gives high runs of d-1 clocks and low-side runs of 63-d clocks.
- R10: Re-enabling the block resets the hold register to 0. Until a new sample is accepted, the duty is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the block; low clears state and releases the outputs |
| dead_en | input | 1 | Inserts one dead clock at each switching edge |
| dither_sel | input | 2 | Dither mode (0 none, 1 ±1, 3 ±2, 2 none) |
| div_val | input | 8 | Sample period in clocks (0 acts as 1) |
| gain_val | input | 8 | Gain code G, gain = (G+1)/256 |
| smp_valid | input | 1 | FIFO has a sample on smp_data |
| smp_data | input | 16 | Signed audio sample from the FIFO |
| smp_req | output | 1 | Sample request, one pulse per sample period |
| hs_drv | output | 1 | High-side (PMOS) on |
| ls_drv | output | 1 | Low-side (NMOS) on |
| hs_oe | output | 1 | High-side output enable |
| ls_oe | output | 1 | Low-side output enable |

## Verification
The main path is driven with samples chosen so that each pattern separates one feature. Positive and negative values at several gains show a real scaling against a pass-through. A sample of -1 at the lowest gain separates floor rounding from truncation. Full-scale values with ±2 dither show saturation against wrap-around. Values placed just below and just above a duty step show which dither modes move the duty and by how much. Dropping `smp_valid` while `smp_data` changes shows that the block holds the old sample rather than reading the bus. Pulse run lengths with and without dead time show the one-clock gap.

// File: rtl/spk_pwm_pkg.sv
// Shared definitions for the speaker PWM output stage.
// Assumes a 16-bit Galois LFSR with a maximal-length tap set.
package spk_pwm_pkg;

    typedef enum logic [1:0] {
        DITH_NONE = 2'd0,
        DITH_PM1  = 2'd1,
        DITH_RSVD = 2'd2,
        DITH_PM2  = 2'd3
    } dith_sel_e;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/spk_rate_gen.sv
// Sample-period timer: asserts tick once every div_val clocks while run is high.
// Assumes div_val of zero behaves like one; the timer restarts whenever run drops.
module spk_rate_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_w;

    assign last_w = (div_val == '0) ? '0 : div_val - DIV_W'(1);
    assign tick   = run && (cnt_q >= last_w);

    // Period counter, wraps on the last count of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q >= last_w) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/spk_dither_lfsr.sv
// Random bit source for dither: Galois LFSR that steps once per sample period.
// Assumes the seed is non-zero; the state reloads the seed while run is low.
module spk_dither_lfsr
    import spk_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic step,
    output logic rnd_bit
);
    logic [LFSR_W-1:0] lfsr_q;

    // Shift register update on each sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            lfsr_q <= LFSR_SEED;
        end else if (step) begin
            lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);
        end
    end

    assign rnd_bit = lfsr_q[0];
endmodule

// File: rtl/spk_sample_proc.sv
// Zero-order hold, fractional gain, dither and saturation of the audio sample.
// Assumes take is already qualified by the request tick and FIFO valid.
// Output is registered: one clock after the hold register changes.
module spk_sample_proc
    import spk_pwm_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                take,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [GAIN_W-1:0]   gain_val,
    input  logic [1:0]          dither_sel,
    input  logic                rnd_bit,
    output logic [SAMPLE_W-1:0] proc_q
);
    localparam int PROD_W = SAMPLE_W + GAIN_W + 2;
    localparam logic signed [PROD_W-1:0] MAXV =
        {{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] MINV =
        {{(PROD_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};
    localparam logic signed [PROD_W-1:0] D1 = PROD_W'(1);
    localparam logic signed [PROD_W-1:0] D2 = PROD_W'(2);

    logic signed [SAMPLE_W-1:0] hold_q;
    logic signed [GAIN_W+1:0]   gain_mul;
    logic signed [PROD_W-1:0]   prod_w;
    logic signed [PROD_W-1:0]   dith_w;
    logic signed [PROD_W-1:0]   sum_w;
    logic        [SAMPLE_W-1:0] sat_w;

    // Hold register: loads only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hold_q <= '0;
        end else if (take) begin
            hold_q <= smp_data;
        end
    end

    assign gain_mul = $signed({2'b00, gain_val}) + $signed((GAIN_W+2)'(1));
    assign prod_w   = PROD_W'(hold_q) * PROD_W'(gain_mul);

    // Dither amplitude and sign selection.
    always_comb begin
        case (dith_sel_e'(dither_sel))
            DITH_PM1: dith_w = rnd_bit ? D1 : -D1;
            DITH_PM2: dith_w = rnd_bit ? D2 : -D2;
            default:  dith_w = '0;
        endcase
    end

    assign sum_w = (prod_w >>> GAIN_W) + dith_w;

    // Clamp the wide sum into the sample range.
    always_comb begin
        if (sum_w > MAXV) begin
            sat_w = MAXV[SAMPLE_W-1:0];
        end else if (sum_w < MINV) begin
            sat_w = MINV[SAMPLE_W-1:0];
        end else begin
            sat_w = sum_w[SAMPLE_W-1:0];
        end
    end

    // Registered processed sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            proc_q <= '0;
        end else begin
            proc_q <= sat_w;
        end
    end
endmodule

// File: rtl/spk_pwm_core.sv
// Free-running PWM carrier and duty compare.
// Assumes PWM_W < SAMPLE_W. The duty level latches at the carrier wrap, and the
// compare uses the carrier padded with ones, so the on-time equals the top
// PWM_W bits of the offset-binary sample.
module spk_pwm_core #(
    parameter int SAMPLE_W = 16,
    parameter int PWM_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [SAMPLE_W-1:0] proc_in,
    output logic                pwm_raw
);
    localparam int PAD_W = SAMPLE_W - PWM_W;

    logic [PWM_W-1:0]    car_q;
    logic [SAMPLE_W-1:0] level_q;
    logic [SAMPLE_W-1:0] offs_w;

    assign offs_w = {~proc_in[SAMPLE_W-1], proc_in[SAMPLE_W-2:0]};

    // Carrier counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            car_q <= '0;
        end else begin
            car_q <= car_q + PWM_W'(1);
        end
    end

    // Duty level, updated only at carrier wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            level_q <= '0;
        end else if (car_q == '1) begin
            level_q <= offs_w;
        end
    end

    assign pwm_raw = run && ({car_q, {PAD_W{1'b1}}} < level_q);
endmodule

// File: rtl/spk_drive_stage.sv
// Complementary gate drive with optional one-clock dead time, plus output enable.
// Assumes pwm_raw is combinational; all outputs are registered.
module spk_drive_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic dead_en,
    input  logic pwm_raw,
    output logic hs_on,
    output logic ls_on,
    output logic oe
);
    logic raw_prev_q;

    // Previous PWM level, used to detect a switching edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            raw_prev_q <= 1'b0;
        end else begin
            raw_prev_q <= pwm_raw;
        end
    end

    // Output enable follows run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe <= 1'b0;
        end else begin
            oe <= run;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_leg
        logic lvl_now;
        logic lvl_prev;
        logic leg_q;
        assign lvl_now  = (i == 0) ? pwm_raw : ~pwm_raw;
        assign lvl_prev = (i == 0) ? raw_prev_q : ~raw_prev_q;
        // Leg on when its level is active and, in dead-time mode, was active last clock too.
        always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
                leg_q <= 1'b0;
            end else begin
                leg_q <= lvl_now && (!dead_en || lvl_prev);
            end
        end
    end

    assign hs_on = g_leg[0].leg_q;
    assign ls_on = g_leg[1].leg_q;
endmodule

// File: rtl/spk_pwm_out.sv
// Top of the audio PWM speaker output stage.
// Assumes the FIFO presents data combinationally with smp_valid in the request cycle.
module spk_pwm_out #(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 8,
    parameter int DIV_W    = 8,
    parameter int PWM_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                dead_en,
    input  logic [1:0]          dither_sel,
    input  logic [DIV_W-1:0]    div_val,
    input  logic [GAIN_W-1:0]   gain_val,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                smp_req,
    output logic                hs_drv,
    output logic                ls_drv,
    output logic                hs_oe,
    output logic                ls_oe
);
    logic                tick_w;
    logic                rnd_w;
    logic [SAMPLE_W-1:0] proc_w;
    logic                raw_w;
    logic                oe_w;

    spk_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(enable), .div_val(div_val), .tick(tick_w)
    );

    spk_dither_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .run(enable), .step(tick_w), .rnd_bit(rnd_w)
    );

    spk_sample_proc #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_proc (
        .clk(clk), .rst_n(rst_n), .run(enable), .take(tick_w && smp_valid),
        .smp_data(smp_data), .gain_val(gain_val), .dither_sel(dither_sel),
        .rnd_bit(rnd_w), .proc_q(proc_w)
    );

    spk_pwm_core #(.SAMPLE_W(SAMPLE_W), .PWM_W(PWM_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(enable), .proc_in(proc_w), .pwm_raw(raw_w)
    );

    spk_drive_stage u_drv (
        .clk(clk), .rst_n(rst_n), .run(enable), .dead_en(dead_en), .pwm_raw(raw_w),
        .hs_on(hs_drv), .ls_on(ls_drv), .oe(oe_w)
    );

    assign smp_req = tick_w;
    assign hs_oe   = oe_w;
    assign ls_oe   = oe_w;
endmodule

// File: rtl/spk_pwm_out_chk.sv
// Assertion checker for spk_pwm_out, attached by bind.
module spk_pwm_out_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             dead_en,
    input logic [DIV_W-1:0] div_val,
    input logic             smp_req,
    input logic             hs_drv,
    input logic             ls_drv,
    input logic             hs_oe,
    input logic             ls_oe
);
    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_drv && ls_drv));

    // R1
    req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !smp_req);

    // R1
    off_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(enable)) |-> (!hs_oe && !ls_oe && !hs_drv && !ls_drv));

    // R1
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enable)) |-> (hs_oe && ls_oe));

    // R8
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enable) && !$past(dead_en)) |-> (hs_drv != ls_drv));

    // R9
    dead_gap_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dead_en) && $past(hs_drv) && !hs_drv) |-> !ls_drv);

    // R9
    dead_gap_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dead_en) && $past(ls_drv) && !ls_drv) |-> !hs_drv);

    // R2
    req_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req && div_val > DIV_W'(1)) |=> (!$stable(div_val) || !smp_req));
endmodule

bind spk_pwm_out spk_pwm_out_chk #(.DIV_W(DIV_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dead_en(dead_en), .div_val(div_val),
    .smp_req(smp_req), .hs_drv(hs_drv), .ls_drv(ls_drv), .hs_oe(hs_oe), .ls_oe(ls_oe)
);

// File: tb/spk_pwm_out_tb_top.sv
module spk_pwm_out_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        dead_en;
    logic [1:0]  dither_sel;
    logic [7:0]  div_val;
    logic [7:0]  gain_val;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        smp_req;
    logic        hs_drv;
    logic        ls_drv;
    logic        hs_oe;
    logic        ls_oe;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    spk_pwm_out dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dead_en(dead_en),
        .dither_sel(dither_sel), .div_val(div_val), .gain_val(gain_val),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_req(smp_req),
        .hs_drv(hs_drv), .ls_drv(ls_drv), .hs_oe(hs_oe), .ls_oe(ls_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_duty(input int s, input int g, input int d);
        int v;
        v = (s * (g + 1)) >>> 8;
        v = v + d;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return (v + 32768) >>> 10;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Length of the next complete high run of one drive (sel_ls picks the low side).
    task automatic run_len(input bit sel_ls, output int len);
        int t = 0;
        len = -1;
        while ((sel_ls ? ls_drv : hs_drv) && t < 400) begin @(negedge clk); t++; end
        while (!(sel_ls ? ls_drv : hs_drv) && t < 400) begin @(negedge clk); t++; end
        if (t >= 400) return;
        len = 0;
        while ((sel_ls ? ls_drv : hs_drv) && len < 400) begin @(negedge clk); len++; end
    endtask

    // Clocks with both drives low after a high-side falling edge.
    task automatic gap_len(output int gap);
        int t = 0;
        gap = -1;
        while (!hs_drv && t < 400) begin @(negedge clk); t++; end
        while (hs_drv && t < 400) begin @(negedge clk); t++; end
        if (t >= 400) return;
        gap = 0;
        while (!ls_drv && gap < 10) begin @(negedge clk); gap++; end
    endtask

    // Clocks from one request pulse to the next.
    task automatic req_gap(output int gap);
        int t = 0;
        gap = -1;
        while (!smp_req && t < 600) begin @(negedge clk); t++; end
        if (t >= 600) return;
        @(negedge clk);
        gap = 1;
        while (!smp_req && gap < 600) begin @(negedge clk); gap++; end
    endtask

    task automatic set_smp(input int s, input int g, input int d, input bit dead);
        smp_data   = 16'(s);
        gain_val   = 8'(g);
        dither_sel = 2'(d);
        dead_en    = dead;
        smp_valid  = 1'b1;
        cyc(300);
    endtask

    task automatic t_reset_off();
        int bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (hs_oe || ls_oe || hs_drv || ls_drv || smp_req) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R1 outputs idle while disabled", bad, 0);
    endtask

    task automatic t_rate();
        int g;
        div_val = 8'd5; enable = 1'b1;
        cyc(3);
        chk(hs_oe && ls_oe, "R1 oe after enable", int'(hs_oe), 1);
        req_gap(g); chk(g == 5, "R2 period div=5", g, 5);
        div_val = 8'd48;
        cyc(60);
        req_gap(g); chk(g == 48, "R2 period div=48", g, 48);
        div_val = 8'd1;
        cyc(3);
        req_gap(g); chk(g == 1, "R2 period div=1", g, 1);
        div_val = 8'd0;
        cyc(3);
        req_gap(g); chk(g == 1, "R2 period div=0 acts as 1", g, 1);
        div_val = 8'd7;
    endtask

    task automatic t_gain();
        int l;
        int e;
        set_smp(16384, 127, 0, 0); e = exp_duty(16384, 127, 0);
        run_len(0, l); chk(l == e, "R4 gain 128/256 positive", l, e);
        set_smp(-16384, 63, 0, 0); e = exp_duty(-16384, 63, 0);
        run_len(0, l); chk(l == e, "R4 gain 64/256 negative", l, e);
        set_smp(-1, 0, 0, 0); e = exp_duty(-1, 0, 0);
        run_len(0, l); chk(l == e, "R4 floor rounding of -1", l, e);
        set_smp(8192, 255, 0, 0); e = exp_duty(8192, 255, 0);
        run_len(0, l); chk(l == e, "R7 unity gain duty", l, e);
        run_len(1, l); chk(l == 64 - e, "R8 low side fills rest", l, 64 - e);
        set_smp(32767, 255, 0, 0);
        run_len(0, l); chk(l == 63, "R7 full-scale duty", l, 63);
    endtask

    task automatic t_sat();
        int l;
        int bad = 0;
        set_smp(32767, 255, 3, 0);
        for (int i = 0; i < 6; i++) begin
            run_len(0, l);
            if (l != 63) bad++;
        end
        chk(bad == 0, "R5 positive saturation holds duty 63", bad, 0);
        set_smp(-32768, 255, 3, 0);
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            if (hs_drv) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R5 negative saturation keeps high side off", bad, 0);
    endtask

    task automatic t_dither_fixed(input int s, input int d, input int e, input string tag);
        int l;
        int bad = 0;
        set_smp(s, 255, d, 0);
        for (int i = 0; i < 6; i++) begin
            run_len(0, l);
            if (l != e) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic t_dither_rand(input int s, input int d, input string tag);
        int l;
        int n39 = 0;
        int n40 = 0;
        int other = 0;
        set_smp(s, 255, d, 0);
        for (int i = 0; i < 14; i++) begin
            run_len(0, l);
            if (l == 39) n39++;
            else if (l == 40) n40++;
            else other++;
        end
        chk(other == 0, {tag, " duty within dither range"}, other, 0);
        chk(n39 > 0 && n40 > 0, {tag, " both duties seen"}, n39 * 100 + n40, 1);
    endtask

    task automatic t_hold();
        int l;
        set_smp(8192, 255, 0, 0);
        smp_valid = 1'b0;
        smp_data  = 16'(-16384);
        cyc(300);
        run_len(0, l); chk(l == 40, "R3 hold when FIFO empty", l, 40);
        smp_valid = 1'b1;
        cyc(300);
        run_len(0, l); chk(l == 16, "R3 new sample taken when valid", l, 16);
    endtask

    task automatic t_dead();
        int l;
        set_smp(8192, 255, 0, 1);
        run_len(0, l); chk(l == 39, "R9 high run with dead time", l, 39);
        run_len(1, l); chk(l == 23, "R9 low run with dead time", l, 23);
        gap_len(l); chk(l == 1, "R9 one dead clock", l, 1);
        dead_en = 1'b0;
        cyc(70);
        gap_len(l); chk(l == 0, "R8 no gap without dead time", l, 0);
    endtask

    task automatic t_reenable();
        int l;
        set_smp(8192, 255, 0, 0);
        enable = 1'b0;
        @(negedge clk);
        chk(!hs_oe && !ls_oe && !hs_drv && !ls_drv, "R1 outputs off after disable",
            int'(hs_oe) + int'(ls_oe) + int'(hs_drv) + int'(ls_drv), 0);
        smp_valid = 1'b0;
        cyc(5);
        enable = 1'b1;
        cyc(300);
        run_len(0, l); chk(l == 32, "R10 hold cleared by disable", l, 32);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; dead_en = 1'b0; dither_sel = 2'd0;
        div_val = 8'd48; gain_val = 8'd255; smp_valid = 1'b0; smp_data = '0;
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        t_reset_off();
        t_rate();
        t_gain();
        t_sat();
        t_dither_fixed(8191, 0, 39, "R6 mode 0 adds nothing");
        t_dither_fixed(8191, 2, 39, "R6 mode 2 adds nothing");
        t_dither_fixed(8193, 1, 40, "R6 mode 1 stays within one step");
        t_dither_rand(8191, 1, "R6 mode 1");
        t_dither_rand(8193, 3, "R6 mode 3");
        t_hold();
        t_dead();
        t_reenable();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule